// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the eight shared PCI interrupt lines (A through H, numbered 0 to 7) and the ACPI system control interrupt (SCI). It delivers them as level-sensitive requests to two interrupt controllers: a 16-input legacy PIC and a 24-input I/O APIC. Each line has a routing byte of its own. The byte picks a PIC pin for that line or turns PIC delivery off. A 3-bit SCI select field picks the one interrupt number the SCI drives. A PIC pin is the OR of every enabled line aimed at it, plus the SCI when the SCI is aimed there. On the APIC side each line owns a fixed input, 16 plus its number, so no two lines share one.

The routing bytes and the SCI select field are written through a simple synchronous write port. For each line the block also reports the route that results: a PIC pin, an APIC input, or off. Software and neighbouring logic can then see where each line lands. The PIRQ levels pass through to the outputs combinationally. The SCI level is registered first, so a change of the SCI reaches the outputs one cycle later.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte holds 0x80, the SCI select holds code 0 and the stored SCI bit is 0. Therefore every line reports APIC input 16+n, and no PIC pin is driven by any line.
- R2: Writes take effect at the next clock edge. Address n (0..7) writes the routing byte of line n: addresses 0..3 hold lines A..D and 4..7 hold lines E..H. Address 8 writes the SCI select from data bits 2:0. Writes to addresses 9..15 change nothing.
- R3: A routing byte holds a disable flag in bit 7 and a target in bits 4:0. PIC pin p is the OR of every line whose flag is 0 and whose target equals p. A line with the flag set, or with a target of 16 or more, drives no PIC pin.
- R4: APIC input 16+n follows line n. APIC inputs 0..15 are never driven by a line.
- R5: SCI select codes 0, 1, 2, 4 and 5 map to interrupts 9, 10, 11, 20 and 21. Codes 3, 6 and 7 deliver the SCI nowhere.
- R6: The selected SCI interrupt is ORed into the APIC input of that number. It is also ORed into the PIC pin of that number when the number is below 16.
- R7: Line level changes appear at the outputs in the same cycle. The SCI level is stored as one bit, sampled at each clock edge, and reaches the outputs one cycle after it changes.
- R8: The route report for line n has a 2-bit mode and a 5-bit number. Mode 0 means PIC, with the target pin as the number; this applies when the flag is 0 and the target is below 16. Mode 2 means off, with number 0; this applies when the flag is 0 and the target is 16 or more. Mode 1 means APIC, with number 16+n; this applies when the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..7 routing, 8 SCI select) |
| wr_data | input | 8 | Write data |
| pirq_i | input | 8 | Levels of the PCI interrupt lines A..H |
| sci_i | input | 1 | ACPI SCI level |
| pic_irq_o | output | 16 | Level requests to the legacy PIC |
| apic_irq_o | output | 24 | Level requests to the I/O APIC |
| route_mode_o | output | 16 | Per-line route mode, 2 bits per line (line n at [2n+1:2n]) |
| route_irq_o | output | 40 | Per-line routed number, 5 bits per line (line n at [5n+4:5n]) |

## Verification
The bench builds the router with its default parameters: eight lines, sixteen PIC pins, twenty-four APIC inputs and a 5-bit target field. The 5-bit target field makes targets of 16 and above possible, so the off route and the PIC silence it implies can be tested. With twenty-four APIC inputs, every SCI code lands on a real input, including 20 and 21. The bench exercises lines that share a PIC pin, OR-merging of the SCI with a line on pin 11, every reserved SCI code, and writes to the unused addresses.

// File: rtl/pirq_router_pkg.sv
// Package: shared types and the SCI select decoder for the interrupt line router.
// Assumes a 3-bit SCI select field and interrupt numbers that fit in 5 bits.
package pirq_router_pkg;

    localparam int IRQ_W   = 5;
    localparam int SEL_W   = 3;
    localparam int ROUTE_W = 8;

    typedef enum logic [1:0] {
        ROUTE_PIC  = 2'd0,
        ROUTE_APIC = 2'd1,
        ROUTE_OFF  = 2'd2
    } route_mode_e;

    typedef struct packed {
        logic             valid;
        logic [IRQ_W-1:0] irq;
    } sci_target_t;

    // Maps an SCI select code to its interrupt number; reserved codes give valid=0.
    function automatic sci_target_t sci_decode(input logic [SEL_W-1:0] sel);
        sci_target_t t;
        t.valid = 1'b1;
        unique case (sel)
            3'd0:    t.irq = 5'd9;
            3'd1:    t.irq = 5'd10;
            3'd2:    t.irq = 5'd11;
            3'd4:    t.irq = 5'd20;
            3'd5:    t.irq = 5'd21;
            default: begin
                t.valid = 1'b0;
                t.irq   = '0;
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
// Module: routing register file. Holds one routing byte per line, the SCI select
// field, and the stored SCI level bit.
// Assumes address n < NUM_PIRQ selects a routing byte, address NUM_PIRQ selects
// the SCI select, and every higher address is ignored.
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int               NUM_PIRQ    = 8,
    parameter int               ADDR_W      = 4,
    parameter logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80,
    parameter logic [SEL_W-1:0] SEL_RESET   = 3'd0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [ROUTE_W-1:0]               wr_data,
    input  logic                             sci_i,
    output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
    output logic [SEL_W-1:0]                 sel_q,
    output logic                             sci_q
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_PIRQ);

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
        // Loads the routing byte of line n on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[n] <= ROUTE_RESET;
            else if (wr_en && wr_addr == ADDR_W'(n))
                route_q[n] <= wr_data;
        end
    end

    // Loads the SCI select field on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= SEL_RESET;
        else if (wr_en && wr_addr == SEL_ADDR)
            sel_q <= wr_data[SEL_W-1:0];
    end

    // Stores the SCI level as one bit; the bit changes only when the input does.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sci_q <= 1'b0;
        else if (sci_i != sci_q)
            sci_q <= sci_i;
    end

    a_r2_ignored_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > SEL_ADDR) |=> ($stable(route_q) && $stable(sel_q)));

    a_r7_sci_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sci_q == $past(sci_i)));

endmodule

// File: rtl/pirq_irq_merge.sv
// Module: OR network. It builds the PIC pin levels and the APIC input levels from
// the line levels, the routing bytes and the stored SCI level.
// Assumes APIC_PINS >= APIC_BASE + NUM_PIRQ and PIC_PINS <= 2**IRQ_W.
module pirq_irq_merge
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_PINS  = 16,
    parameter int APIC_PINS = 24,
    parameter int APIC_BASE = 16,
    parameter int TGT_W     = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
    input  logic [SEL_W-1:0]                 sel_q,
    input  logic                             sci_q,
    input  logic [NUM_PIRQ-1:0]              pirq_i,
    output logic [PIC_PINS-1:0]              pic_o,
    output logic [APIC_PINS-1:0]             apic_o
);

    localparam int DIS_BIT = ROUTE_W - 1;

    sci_target_t sci_tgt;
    logic [PIC_PINS-1:0]  sci_pic_hit;
    logic [APIC_PINS-1:0] sci_apic_hit;

    // Decodes the SCI select into one-hot hits on each controller.
    always_comb begin
        sci_tgt      = sci_decode(sel_q);
        sci_pic_hit  = '0;
        sci_apic_hit = '0;
        for (int p = 0; p < PIC_PINS; p++)
            if (sci_tgt.valid && sci_tgt.irq == IRQ_W'(p))
                sci_pic_hit[p] = 1'b1;
        for (int a = 0; a < APIC_PINS; a++)
            if (sci_tgt.valid && sci_tgt.irq == IRQ_W'(a))
                sci_apic_hit[a] = 1'b1;
    end

    for (genvar p = 0; p < PIC_PINS; p++) begin : g_pic
        logic line_or;
        // ORs every enabled line whose target is pin p, then adds the SCI.
        always_comb begin
            line_or = 1'b0;
            for (int n = 0; n < NUM_PIRQ; n++)
                if (!route_q[n][DIS_BIT] && route_q[n][TGT_W-1:0] == TGT_W'(p))
                    line_or = line_or | pirq_i[n];
            pic_o[p] = line_or | (sci_pic_hit[p] & sci_q);
        end
    end

    for (genvar a = 0; a < APIC_PINS; a++) begin : g_apic
        if (a >= APIC_BASE && a < APIC_BASE + NUM_PIRQ) begin : g_line
            // Fixed APIC input of one line, shared only with the SCI.
            always_comb apic_o[a] = pirq_i[a-APIC_BASE] | (sci_apic_hit[a] & sci_q);

            a_r4_apic_fixed: assert property (@(posedge clk) disable iff (!rst_n)
                !sci_apic_hit[a] |-> (apic_o[a] == pirq_i[a-APIC_BASE]));
        end else begin : g_free
            // APIC input not owned by a line: only the SCI can drive it.
            always_comb apic_o[a] = sci_apic_hit[a] & sci_q;
        end
    end

    a_r3_pic_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_i == '0 && (sci_pic_hit == '0 || !sci_q)) |-> (pic_o == '0));

    a_r5_sci_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd3 || sel_q == 3'd6 || sel_q == 3'd7) |-> (apic_o[APIC_BASE-1:0] == '0));

    a_r6_sci_on_pic: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd1 && sci_q) |-> pic_o[10] && apic_o[10]);

endmodule

// File: rtl/pirq_route_report.sv
// Module: per-line route report. For each line it gives the resolved mode and
// number: a PIC pin, the fixed APIC input, or off.
// Assumes APIC_BASE + NUM_PIRQ - 1 fits in IRQ_W bits.
module pirq_route_report
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_PINS  = 16,
    parameter int APIC_BASE = 16,
    parameter int TGT_W     = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
    output logic [NUM_PIRQ-1:0][1:0]         mode_o,
    output logic [NUM_PIRQ-1:0][IRQ_W-1:0]   irq_o
);

    localparam int DIS_BIT = ROUTE_W - 1;

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_line
        logic [TGT_W-1:0] tgt;
        // Resolves the route of line n from its routing byte.
        always_comb begin
            tgt = route_q[n][TGT_W-1:0];
            if (route_q[n][DIS_BIT]) begin
                mode_o[n] = ROUTE_APIC;
                irq_o[n]  = IRQ_W'(APIC_BASE + n);
            end else if (int'(tgt) < PIC_PINS) begin
                mode_o[n] = ROUTE_PIC;
                irq_o[n]  = IRQ_W'(tgt);
            end else begin
                mode_o[n] = ROUTE_OFF;
                irq_o[n]  = '0;
            end
        end

        a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
            mode_o[n] != 2'd3);

        a_r8_apic_number: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_o[n] == ROUTE_APIC) |-> (irq_o[n] == IRQ_W'(APIC_BASE + n)));
    end

endmodule

// File: rtl/pirq_router.sv
// Module: top of the interrupt line router. It connects the register file, the
// OR network and the route report.
// Assumes a synchronous active-low reset. Line levels are used combinationally;
// the SCI level passes through a register first.
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_PINS  = 16,
    parameter int APIC_PINS = 24,
    parameter int APIC_BASE = 16,
    parameter int TGT_W     = 5,
    parameter int ADDR_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [NUM_PIRQ-1:0]       pirq_i,
    input  logic                      sci_i,
    output logic [PIC_PINS-1:0]       pic_irq_o,
    output logic [APIC_PINS-1:0]      apic_irq_o,
    output logic [2*NUM_PIRQ-1:0]     route_mode_o,
    output logic [IRQ_W*NUM_PIRQ-1:0] route_irq_o
);

    logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
    logic [SEL_W-1:0]                 sel_q;
    logic                             sci_q;
    logic [NUM_PIRQ-1:0][1:0]         mode_w;
    logic [NUM_PIRQ-1:0][IRQ_W-1:0]   irq_w;

    pirq_route_regs #(
        .NUM_PIRQ (NUM_PIRQ),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sci_i   (sci_i),
        .route_q (route_q),
        .sel_q   (sel_q),
        .sci_q   (sci_q)
    );

    pirq_irq_merge #(
        .NUM_PIRQ  (NUM_PIRQ),
        .PIC_PINS  (PIC_PINS),
        .APIC_PINS (APIC_PINS),
        .APIC_BASE (APIC_BASE),
        .TGT_W     (TGT_W)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .route_q (route_q),
        .sel_q   (sel_q),
        .sci_q   (sci_q),
        .pirq_i  (pirq_i),
        .pic_o   (pic_irq_o),
        .apic_o  (apic_irq_o)
    );

    pirq_route_report #(
        .NUM_PIRQ  (NUM_PIRQ),
        .PIC_PINS  (PIC_PINS),
        .APIC_BASE (APIC_BASE),
        .TGT_W     (TGT_W)
    ) u_report (
        .clk     (clk),
        .rst_n   (rst_n),
        .route_q (route_q),
        .mode_o  (mode_w),
        .irq_o   (irq_w)
    );

    // Flattens the per-line report onto the output buses.
    always_comb begin
        route_mode_o = mode_w;
        route_irq_o  = irq_w;
    end

endmodule

// File: tb/pirq_router_test.sv
// Bench: scoreboard. The driver applies stimulus, updates a model built from the
// requirements and queues the expected outputs; the monitor pops and compares them.
module pirq_router_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] pic;
        logic [23:0] apic;
        logic [15:0] mode;
        logic [39:0] irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  pirq_i = '0;
    logic        sci_i = 1'b0;
    logic [15:0] pic_irq_o;
    logic [23:0] apic_irq_o;
    logic [15:0] route_mode_o;
    logic [39:0] route_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t exp_q[$];

    logic [7:0] m_route [8];
    logic [2:0] m_sel;
    logic       m_sci;

    pirq_router uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pirq_i       (pirq_i),
        .sci_i        (sci_i),
        .pic_irq_o    (pic_irq_o),
        .apic_irq_o   (apic_irq_o),
        .route_mode_o (route_mode_o),
        .route_irq_o  (route_irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model reset state (R1).
    task automatic model_reset();
        for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
        m_sel = 3'd0;
        m_sci = 1'b0;
    endtask

    // One clock: the model follows the register updates (R2, R7).
    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (wr_en && wr_addr < 4'd8) m_route[wr_addr[2:0]] = wr_data;
            else if (wr_en && wr_addr == 4'd8) m_sel = wr_data[2:0];
            m_sci = sci_i;
        end
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    // Expected outputs from the requirements; queued for the monitor.
    task automatic expect_now(input string tag);
        exp_t e;
        int   si;
        bit   sv;
        e.pic = '0; e.apic = '0; e.mode = '0; e.irq = '0; e.tag = tag;
        for (int n = 0; n < 8; n++) begin
            if (!m_route[n][7] && m_route[n][4:0] < 5'd16)
                e.pic[m_route[n][3:0]] |= pirq_i[n];
            e.apic[16+n] = pirq_i[n];
            if (m_route[n][7]) begin
                e.mode[2*n +: 2] = 2'd1; e.irq[5*n +: 5] = 5'(16+n);
            end else if (m_route[n][4:0] < 5'd16) begin
                e.mode[2*n +: 2] = 2'd0; e.irq[5*n +: 5] = m_route[n][4:0];
            end else begin
                e.mode[2*n +: 2] = 2'd2; e.irq[5*n +: 5] = 5'd0;
            end
        end
        sv = 1'b1;
        case (m_sel)
            3'd0: si = 9;
            3'd1: si = 10;
            3'd2: si = 11;
            3'd4: si = 20;
            3'd5: si = 21;
            default: begin si = 0; sv = 1'b0; end
        endcase
        if (sv) begin
            e.apic[si] |= m_sci;
            if (si < 16) e.pic[si] |= m_sci;
        end
        #1;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    // Monitor: pops each expected item and compares it with the outputs.
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            checks++;
            if (pic_irq_o !== e.pic || apic_irq_o !== e.apic ||
                route_mode_o !== e.mode || route_irq_o !== e.irq) begin
                fails++;
                $display("FAIL %s: pic=%h/%h apic=%h/%h mode=%h/%h irq=%h/%h (actual/expected)",
                         e.tag, pic_irq_o, e.pic, apic_irq_o, e.apic,
                         route_mode_o, e.mode, route_irq_o, e.irq);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        tick(); tick();
        expect_now("R1 reset state, lines idle");
        rst_n = 1'b1;
        tick();
        pirq_i = 8'hFF;
        expect_now("R1 R4 all lines high after reset, APIC only");
        pirq_i = 8'h5A;
        expect_now("R4 R7 same-cycle line change on APIC");

        // Routing: lines 0 and 1 share pin 5, line 2 on 11, line 4 target 20 (off).
        write_reg(4'd0, 8'h05);
        write_reg(4'd1, 8'h05);
        write_reg(4'd2, 8'h0B);
        write_reg(4'd4, 8'h14);
        write_reg(4'd7, 8'h8F);
        pirq_i = 8'h00;
        expect_now("R2 R8 route report after writes");
        pirq_i = 8'h01;
        expect_now("R3 line 0 onto pin 5");
        pirq_i = 8'h02;
        expect_now("R3 line 1 alone onto shared pin 5");
        pirq_i = 8'h10;
        expect_now("R3 R8 high target drives no PIC pin");
        pirq_i = 8'h80;
        expect_now("R3 disable flag blocks PIC for line 7");
        pirq_i = 8'h07;
        expect_now("R3 multiple lines ORed");

        // SCI: code 0 -> 9, registered one cycle.
        pirq_i = 8'h00;
        sci_i  = 1'b1;
        expect_now("R7 SCI not yet visible before clock");
        tick();
        expect_now("R5 R6 SCI on pin 9 after one cycle");
        write_reg(4'd8, 8'h02);
        pirq_i = 8'h04;
        expect_now("R6 SCI ORed with line 2 on pin 11");
        sci_i = 1'b0;
        tick();
        expect_now("R6 line 2 holds pin 11 after SCI drops");
        sci_i = 1'b1;
        tick();
        write_reg(4'd8, 8'h04);
        expect_now("R5 code 4 targets APIC 20 only");
        write_reg(4'd8, 8'h05);
        expect_now("R5 code 5 targets APIC 21");
        write_reg(4'd8, 8'h01);
        expect_now("R5 code 1 targets pin 10");
        write_reg(4'd8, 8'h03);
        expect_now("R5 reserved code 3 delivers nowhere");
        write_reg(4'd8, 8'h06);
        expect_now("R5 reserved code 6 delivers nowhere");
        write_reg(4'd8, 8'h07);
        expect_now("R5 reserved code 7 delivers nowhere");

        // Unused addresses must not alter any state.
        for (int a = 9; a < 16; a++) write_reg(4'(a), 8'h00);
        expect_now("R2 writes to addresses 9..15 ignored");
        write_reg(4'd8, 8'h00);
        pirq_i = 8'hFF;
        expect_now("R2 R6 routes and SCI select after ignored writes");

        // Reset while SCI is high: stored SCI bit cleared, routes default.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        expect_now("R1 reset clears routes and stored SCI");
        tick();
        expect_now("R7 SCI returns one cycle after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule